// File: doc/BRIEF.md
# Microprogram Sequencer and Microword Fetch

This block chooses which microinstruction of the current machine instruction is active. It keeps a small state register that moves forward once per short-word time. That time is marked by a run qualifier together with the last bit period of the short-word cycle. When it moves, the state register does one of three things: it clears to zero, it jumps to a microbranch target, or it increments.

The microaddress is the concatenation of the instruction's operation field, its length bit and the state number. Each operation/length pair therefore owns its own 16-entry slot of microcode. The microcode is a 32-bit-wide constant table held inside the block and read combinationally from that address. Because the address only changes at the advance edge, or when the instruction fields change, the microword stays steady for a whole short-word time. The block exposes the microword and the state number. What each microword bit controls is decided elsewhere.

Top module: `mseq_top`

## Requirements
- R1: An active-low asynchronous reset (`rst_n` = 0) forces the state number to 0.
- R2: The state number changes only on a rising clock edge where `run_en` and `bit_last` are both 1 (an advance edge). On every other edge it holds, whatever `clr_state`, `br_take` and `br_target` are.
- R3: On an advance edge with `clr_state` = 1, the state becomes 0. This holds even when `br_take` = 1, so clearing has the highest priority.
- R4: On an advance edge with `clr_state` = 0 and `br_take` = 1, the state becomes `br_target`.
- R5: On an advance edge with neither `clr_state` nor `br_take`, the state increments by one and wraps from 15 to 0.
- R6: The microaddress is 10 bits: `opcode` in bits 9..5, `len_bit` in bit 4 and the state in bits 3..0. `uword` follows a change of `opcode` or `len_bit` within the same cycle, with no clock edge.
- R7: The table entry at address a is ((a × 0x9E3779B1) mod 2^32) XOR a.
- R8: The `state` output always equals the sequencer state that results from applying R1 to R5 in order, for any mix of inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Machine running qualifier |
| bit_last | input | 1 | Last bit period of the short-word cycle |
| clr_state | input | 1 | Return to state 0 at the next advance |
| br_take | input | 1 | Take the microbranch at the next advance |
| br_target | input | 4 | Microbranch destination state |
| opcode | input | 5 | Operation field of the current instruction |
| len_bit | input | 1 | Short/long length bit of the current instruction |
| uword | output | 32 | Microword at the current microaddress |
| state | output | 4 | Current state number |

## Verification
The hardest cases to reach are those where the control inputs disagree. One is a clear and a branch requested on the same advance edge. Another is a clear or branch held active on edges that are not advance edges, where it must leave the state alone. A further case is the wrap from 15 to 0, which only appears after sixteen consecutive plain advances. The stimulus first drives each of these deliberately. It then runs a long stretch in which the qualifiers, requests, targets and instruction fields all change independently, so that the three transitions and the hold interleave in many orders. A behavioural model follows the bench every cycle, and the combinational path is checked a moment after each change of the instruction fields.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_CLEAR = 2'd1,
    ACT_JUMP  = 2'd2,
    ACT_NEXT  = 2'd3
  } seq_act_e;

  // Decide what the state register does on this edge
  function automatic seq_act_e pick_act(input logic step, input logic clr,
                                        input logic take);
    if (!step)     return ACT_HOLD;
    else if (clr)  return ACT_CLEAR;
    else if (take) return ACT_JUMP;
    else           return ACT_NEXT;
  endfunction

  // Constant table contents: multiplicative hash folded with the address
  function automatic logic [31:0] rom_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ a;
  endfunction

endpackage

// File: rtl/mseq_state_ctr.sv
module mseq_state_ctr #(
  parameter int ST_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            clr,
  input  logic            take,
  input  logic [ST_W-1:0] target,
  output logic [ST_W-1:0] state_q
);
  import mseq_pkg::*;

  seq_act_e        act;
  logic [ST_W-1:0] state_d;

  assign act = pick_act(step, clr, take);

  always_comb begin
    unique case (act)
      ACT_CLEAR: state_d = '0;
      ACT_JUMP:  state_d = target;
      ACT_NEXT:  state_d = state_q + ST_W'(1);
      default:   state_d = state_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> state_q == '0); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(state_q)); // R2
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && clr) |=> state_q == '0); // R3
  AST_BRANCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && take) |=> state_q == $past(target)); // R4
  AST_PLAIN_INCR: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !take) |=> state_q == ST_W'($past(state_q) + 1'b1)); // R5

endmodule

// File: rtl/mseq_addr_gen.sv
module mseq_addr_gen #(
  parameter int OPC_W = 5,
  parameter int ST_W  = 4,
  localparam int AW   = OPC_W + 1 + ST_W
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic             len_bit,
  input  logic [ST_W-1:0]  state,
  output logic [AW-1:0]    uaddr
);
  // Each opcode/length pair owns a 2**ST_W slot
  assign uaddr = {opcode, len_bit, state};
endmodule

// File: rtl/mseq_rom.sv
module mseq_rom #(
  parameter int AW   = 10,
  parameter int UW_W = 32,
  localparam int DEPTH = 1 << AW
) (
  input  logic [AW-1:0]   addr,
  output logic [UW_W-1:0] data
);
  logic [UW_W-1:0] tab [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign tab[g] = UW_W'(mseq_pkg::rom_word(32'(g)));
  end

  assign data = tab[addr];
endmodule

// File: rtl/mseq_top.sv
module mseq_top #(
  parameter int OPC_W = 5,
  parameter int ST_W  = 4,
  parameter int UW_W  = 32,
  localparam int AW   = OPC_W + 1 + ST_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             bit_last,
  input  logic             clr_state,
  input  logic             br_take,
  input  logic [ST_W-1:0]  br_target,
  input  logic [OPC_W-1:0] opcode,
  input  logic             len_bit,
  output logic [UW_W-1:0]  uword,
  output logic [ST_W-1:0]  state
);
  logic          adv_step;
  logic [AW-1:0] uaddr;

  assign adv_step = run_en & bit_last;

  mseq_state_ctr #(.ST_W(ST_W)) ctr_i (
    .clk(clk), .rst_n(rst_n), .step(adv_step), .clr(clr_state),
    .take(br_take), .target(br_target), .state_q(state)
  );

  mseq_addr_gen #(.OPC_W(OPC_W), .ST_W(ST_W)) agen_i (
    .opcode(opcode), .len_bit(len_bit), .state(state), .uaddr(uaddr)
  );

  mseq_rom #(.AW(AW), .UW_W(UW_W)) rom_i (
    .addr(uaddr), .data(uword)
  );

  AST_WORD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(state) && $stable(opcode) && $stable(len_bit)) |-> $stable(uword)); // R6

endmodule

// File: tb/mseq_top_tb_top.sv
module mseq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0, bit_last = 1'b0, clr_state = 1'b0, br_take = 1'b0;
  logic [3:0]  br_target = '0;
  logic [4:0]  opcode = '0;
  logic        len_bit = 1'b0;
  logic [31:0] uword;
  logic [3:0]  state;

  int n_chk = 0;
  int n_bad = 0;
  int ref_st = 0;

  always #5 clk = ~clk;

  mseq_top dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .bit_last(bit_last),
    .clr_state(clr_state), .br_take(br_take), .br_target(br_target),
    .opcode(opcode), .len_bit(len_bit), .uword(uword), .state(state)
  );

  // Behavioural reference of the state register
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_st <= 0;
    else if (run_en && bit_last) begin
      if (clr_state)    ref_st <= 0;
      else if (br_take) ref_st <= int'(br_target);
      else              ref_st <= (ref_st + 1) % 16;
    end
  end

  function automatic logic [31:0] exp_word(input int op, input int ln, input int st);
    longint a;
    longint p;
    a = longint'(op) * 32 + longint'(ln) * 16 + longint'(st);
    p = (a * 64'h9E3779B1) % 64'h1_0000_0000;
    return 32'(p) ^ 32'(a);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // At a negedge: drive one cycle's inputs, check the combinational word,
  // then at the next negedge check the registered state and its word.
  task automatic cyc(input string req, input logic r, input logic l, input logic c,
                     input logic b, input logic [3:0] t, input logic [4:0] o,
                     input logic n);
    run_en = r; bit_last = l; clr_state = c; br_take = b; br_target = t;
    opcode = o; len_bit = n;
    #1;
    check("R6", uword, exp_word(int'(o), int'(n), ref_st));
    @(negedge clk);
    check(req, 32'(state), 32'(ref_st));
    check("R7", uword, exp_word(int'(opcode), int'(len_bit), ref_st));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 32'(state), 32'd0);
    check("R7", uword, exp_word(0, 0, 0));
    rst_n = 1'b1;
    @(negedge clk);
    // plain increments through the wrap (17 steps: 0..15, 0, 1)
    for (int i = 0; i < 17; i++) cyc("R5", 1, 1, 0, 0, 4'h0, 5'd3, 1);
    check("R5", 32'(state), 32'd1);
    // requests without an advance edge must leave the state alone
    for (int i = 0; i < 4; i++) cyc("R2", 1, 0, 1, 1, 4'hA, 5'd7, 0);
    for (int i = 0; i < 4; i++) cyc("R2", 0, 1, 0, 1, 4'h6, 5'd7, 0);
    check("R2", 32'(state), 32'd1);
    cyc("R4", 1, 1, 0, 1, 4'h9, 5'd12, 1);
    check("R4", 32'(state), 32'd9);
    cyc("R3", 1, 1, 1, 1, 4'hE, 5'd12, 1);
    check("R3", 32'(state), 32'd0);
    cyc("R4", 1, 1, 0, 1, 4'hF, 5'd31, 1);
    cyc("R5", 1, 1, 0, 0, 4'h0, 5'd31, 1);
    check("R5", 32'(state), 32'd0);
    // instruction field change alone moves the word within the cycle
    cyc("R6", 0, 0, 0, 0, 4'h0, 5'd17, 0);
    // mixed stimulus
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] rv;
      rv = 8'($urandom);
      cyc("R8", rv[0] | rv[1], rv[2] | rv[3], rv[4] & rv[5], rv[6],
          4'($urandom), (rv[7] ? 5'($urandom) : opcode), rv[7] ? 1'($urandom) : len_bit);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule